// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller with Timed Refresh

This block sits between a simple host request port and one 4M x 4 EDO DRAM. The host offers one 4-bit word at a time with a 22-bit word address and a valid/ready handshake. Writes complete silently. Reads return their data on a one-cycle response strobe, in request order. The controller splits each address into a 12-bit row and a 10-bit column and places them in turn on a shared 12-bit address bus. It drives the active-low row strobe, column strobe, write enable and output enable. Write data goes out on a separate output with its own drive enable, and read data comes back on a separate input.

After the first access, a row stays open. Later requests to the same row are served as short page cycles that toggle only the column strobe. A request to another row first raises the row strobe for a precharge. A timer, derived from the clock period, asks for a column-before-row refresh at 4096 refreshes per 64 ms. A pending refresh blocks new host requests and closes any open row before it runs. An open row is also closed once it has been held for a configurable maximum time. Every timing limit is given in nanoseconds and turned into clock cycles at elaboration.

Top module: `edo_page_ctrl`

## Requirements
- R1: From reset until the power-up wait of INIT_NS has elapsed:
  - the row, column, write and output-enable strobes all stay high;
  - the data drive enable stays low;
  - req_ready stays low.
- R2: Host address bits [21:10] appear on dram_addr while the row strobe falls. Bits [9:0] appear, with dram_addr[11:10] zero, while the column strobe falls.
- R3: During a write, dram_we_n is low and dram_dq_oe is high for the whole time the column strobe is low, with write data on dram_dq_out. At all other times dram_dq_oe is low.
- R4: dram_oe_n is low only while a read holds the column strobe low. Read data is sampled no earlier than all three of these limits:
  - 50 ns after the row strobe falls;
  - 13 ns after the column strobe falls;
  - 25 ns after the column address is applied.

  rsp_valid pulses for one cycle with that data on the cycle after sampling.
- R5: Accesses to the row already open cause no new row strobe fall. Back-to-back same-row accesses start a new column strobe every CAC+1 cycles, which is 5 cycles at the default timing.
- R6: Before a new row is opened, the row strobe stays high for at least the precharge time, which is 4 cycles at the default timing.
- R7: Refresh runs as column strobe low for at least one cycle before the row strobe falls, with no row address needed. One refresh is issued per 64 ms / 4096 of time.
- R8: A refresh that falls due while a row is open closes that row before the refresh runs. It is served within a bounded number of cycles, and no host request is accepted while it is pending.
- R9: An open row that sees no access is closed after RAS_MAX_NS. The row strobe is never held low longer than that limit plus one column access.
- R10: Successive row strobe falls are at least 84 ns apart. This holds for accesses and for refreshes.
- R11: Read responses return in the order the reads were accepted, and each carries the data most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:10], column in [9:0] |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 4 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
The embedded properties assume the following about the inputs:
- the timing parameters make the precharge at least two cycles;
- the refresh period is longer than one row cycle, so a refresh is never requested again while the last one is still pending;
- the memory presents stable read data at the cycle the controller samples.

The bench keeps within these limits:
- it uses a refresh period of about 400 cycles and a short RAS limit, so refresh and row timeout occur often;
- its inline memory model answers only with data that has met the access-time limits;
- it drives requests only between clock edges and holds each one until the handshake completes.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

  typedef enum logic [2:0] {
    S_INIT = 3'd0,
    S_IDLE = 3'd1,
    S_ACT  = 3'd2,
    S_COL  = 3'd3,
    S_OPEN = 3'd4,
    S_PRE  = 3'd5,
    S_REFC = 3'd6,
    S_REFR = 3'd7
  } edo_state_e;

  // Round a time in ns up to whole clock cycles
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_ref_timer.sv
`timescale 1ns/1ps
module edo_ref_timer #(
  parameter int unsigned PERIOD   = 1953,
  parameter int unsigned WAIT_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int unsigned CNT_W  = $clog2(PERIOD + 1);
  localparam int unsigned WAIT_W = $clog2(WAIT_MAX + 3);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              tick;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      cnt_d = tick ? CNT_W'(PERIOD - 1) : cnt_q - 1'b1;
    end
    pend_d = pend_q;
    if (ref_ack) pend_d = 1'b0;
    if (tick)    pend_d = 1'b1;
    wait_d = '0;
    if (pend_q) wait_d = (wait_q == '1) ? wait_q : wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(PERIOD - 1);
      pend_q <= 1'b0;
      wait_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      wait_q <= wait_d;
    end
  end

  assign ref_pend = pend_q;

  // R8: a pending refresh is taken up within a bounded wait
  p_ref_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (wait_q <= WAIT_W'(WAIT_MAX)));

endmodule

// File: rtl/edo_row_track.sv
`timescale 1ns/1ps
module edo_row_track #(
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned AGE_MAX   = 1250,
  parameter int unsigned AGE_SLACK = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close_en,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             row_hit,
  output logic             age_expired
);
  localparam int unsigned AGE_W = $clog2(AGE_MAX + AGE_SLACK + 2);

  logic             valid_q, valid_d;
  logic [ROW_W-1:0] row_q;
  logic [AGE_W-1:0] age_q, age_d;

  always_comb begin
    valid_d = valid_q;
    age_d   = age_q;
    if (close_en) begin
      valid_d = 1'b0;
      age_d   = '0;
    end else if (open_en) begin
      valid_d = 1'b1;
      age_d   = '0;
    end else if (valid_q && (age_q != '1)) begin
      age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      age_q   <= '0;
    end else begin
      valid_q <= valid_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (open_en) row_q <= open_row;
  end

  assign row_hit     = valid_q && (row_q == cmp_row);
  assign age_expired = valid_q && (age_q >= AGE_W'(AGE_MAX));

  // R9: an open row never outlives its limit plus one column access
  p_ras_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (age_q <= AGE_W'(AGE_MAX + AGE_SLACK)));

endmodule

// File: rtl/edo_access_fsm.sv
`timescale 1ns/1ps
module edo_access_fsm
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned BUS_W    = 12,
  parameter int unsigned DQ_W     = 4,
  parameter int unsigned INIT_CYC = 25000,
  parameter int unsigned RCD_CYC  = 3,
  parameter int unsigned CAC_CYC  = 4,
  parameter int unsigned RP_CYC   = 4,
  parameter int unsigned REFL_CYC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_we,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [DQ_W-1:0]  req_wdata,
  output logic             rsp_valid,
  output logic [DQ_W-1:0]  rsp_rdata,
  input  logic             row_hit,
  input  logic             ras_expired,
  input  logic             ref_pend,
  output logic             ref_ack,
  output logic             trk_open,
  output logic [ROW_W-1:0] trk_row,
  output logic             trk_close,
  output logic             timer_run,
  output logic [BUS_W-1:0] dram_addr,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  input  logic [DQ_W-1:0]  dq_in
);
  localparam int unsigned TMR_W = $clog2(INIT_CYC + RCD_CYC + CAC_CYC + RP_CYC + REFL_CYC + 2);

  edo_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_done;
  logic             pend_q, pend_d;
  logic             we_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DQ_W-1:0]  wd_q;
  logic [DQ_W-1:0]  rd_q;
  logic             rd_en;
  logic             rv_q, rv_d;
  logic             accept;

  assign tmr_done  = (tmr_q == '0);
  assign req_ready = ((st_q == S_IDLE) || ((st_q == S_OPEN) && !ras_expired)) && !ref_pend;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_d      = st_q;
    tmr_d     = tmr_done ? tmr_q : tmr_q - 1'b1;
    pend_d    = pend_q | accept;
    rv_d      = 1'b0;
    rd_en     = 1'b0;
    trk_open  = 1'b0;
    trk_close = 1'b0;
    unique case (st_q)
      S_INIT: if (tmr_done) st_d = S_IDLE;
      S_IDLE: begin
        if (ref_pend) begin
          st_d  = S_REFC;
          tmr_d = '0;
        end else if (accept) begin
          st_d     = S_ACT;
          tmr_d    = TMR_W'(RCD_CYC - 1);
          trk_open = 1'b1;
        end
      end
      S_ACT: begin
        if (tmr_done) begin
          st_d  = S_COL;
          tmr_d = TMR_W'(CAC_CYC - 1);
        end
      end
      S_COL: begin
        if (tmr_done) begin
          st_d   = S_OPEN;
          pend_d = 1'b0;
          rd_en  = !we_q;
          rv_d   = !we_q;
        end
      end
      S_OPEN: begin
        if (ref_pend || ras_expired) begin
          st_d      = S_PRE;
          tmr_d     = TMR_W'(RP_CYC - 1);
          trk_close = 1'b1;
        end else if (accept) begin
          if (row_hit) begin
            st_d  = S_COL;
            tmr_d = TMR_W'(CAC_CYC - 1);
          end else begin
            st_d      = S_PRE;
            tmr_d     = TMR_W'(RP_CYC - 1);
            trk_close = 1'b1;
          end
        end
      end
      S_PRE: begin
        if (tmr_done) begin
          if (ref_pend) begin
            st_d  = S_REFC;
            tmr_d = '0;
          end else if (pend_q) begin
            st_d     = S_ACT;
            tmr_d    = TMR_W'(RCD_CYC - 1);
            trk_open = 1'b1;
          end else begin
            st_d = S_IDLE;
          end
        end
      end
      S_REFC: begin
        st_d  = S_REFR;
        tmr_d = TMR_W'(REFL_CYC - 1);
      end
      S_REFR: begin
        if (tmr_done) begin
          st_d  = S_PRE;
          tmr_d = TMR_W'(RP_CYC - 1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_INIT;
      tmr_q  <= TMR_W'(INIT_CYC - 1);
      pend_q <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      rv_q   <= rv_d;
    end
  end

  // request latch, clock-enabled by the handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      row_q <= '0;
      col_q <= '0;
      wd_q  <= '0;
    end else if (accept) begin
      we_q  <= req_we;
      row_q <= req_row;
      col_q <= req_col;
      wd_q  <= req_wdata;
    end
  end

  // read capture, clock-enabled at the end of a read column access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= dq_in;
  end

  assign trk_row   = accept ? req_row : row_q;
  assign ref_ack   = (st_q == S_REFC);
  assign timer_run = (st_q != S_INIT);
  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;

  always_comb begin
    ras_n     = !((st_q == S_ACT) || (st_q == S_COL) || (st_q == S_OPEN) || (st_q == S_REFR));
    cas_n     = !((st_q == S_COL) || (st_q == S_REFC) || (st_q == S_REFR));
    we_n      = !((st_q == S_COL) && we_q);
    oe_n      = !((st_q == S_COL) && !we_q);
    dq_oe     = (st_q == S_COL) && we_q;
    dq_out    = wd_q;
    dram_addr = '0;
    if (st_q == S_ACT)                          dram_addr = BUS_W'(row_q);
    else if ((st_q == S_COL) || (st_q == S_OPEN)) dram_addr = BUS_W'(col_q);
  end

  // R3: data is driven only under an active write column strobe
  p_wr_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !cas_n && !ras_n && oe_n));

  // R4: a response follows a read column access of the previous cycle
  p_rsp_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!cas_n) && $past(!oe_n) && $past(we_n)));

endmodule

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned CLK_PS        = 8000,
  parameter int unsigned ROW_W         = 12,
  parameter int unsigned COL_W         = 10,
  parameter int unsigned DQ_W          = 4,
  parameter int unsigned RAC_NS        = 50,
  parameter int unsigned CAC_NS        = 13,
  parameter int unsigned AA_NS         = 25,
  parameter int unsigned RC_NS         = 84,
  parameter int unsigned RP_NS         = 30,
  parameter int unsigned RAS_MIN_NS    = 50,
  parameter int unsigned RAS_MAX_NS    = 10000,
  parameter int unsigned REF_WINDOW_US = 64000,
  parameter int unsigned REF_ROWS      = 4096,
  parameter int unsigned INIT_NS       = 200000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]          req_wdata,
  output logic                     rsp_valid,
  output logic [DQ_W-1:0]          rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [DQ_W-1:0]          dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DQ_W-1:0]          dram_dq_in
);
  localparam int unsigned BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned CAC_CYC  = umax(umax(ns2cyc(CAC_NS, CLK_PS), ns2cyc(AA_NS, CLK_PS)), 1);
  localparam int unsigned RAC_CYC  = ns2cyc(RAC_NS, CLK_PS);
  localparam int unsigned RCD_CYC  = (RAC_CYC > CAC_CYC + 1) ? RAC_CYC - CAC_CYC : 1;
  localparam int unsigned RC_CYC   = ns2cyc(RC_NS, CLK_PS);
  localparam int unsigned RP_MIN   = umax(ns2cyc(RP_NS, CLK_PS), 2);
  localparam int unsigned RP_CYC   = (RC_CYC > RCD_CYC + CAC_CYC + 1 + RP_MIN) ?
                                     RC_CYC - RCD_CYC - CAC_CYC - 1 : RP_MIN;
  localparam int unsigned REFL_CYC = umax(ns2cyc(RAS_MIN_NS, CLK_PS), 1);
  localparam int unsigned REF_CYC  = ((REF_WINDOW_US * 1000) / REF_ROWS) * 1000 / CLK_PS;
  localparam int unsigned RASX_CYC = ns2cyc(RAS_MAX_NS, CLK_PS);
  localparam int unsigned INIT_CYC = umax(ns2cyc(INIT_NS, CLK_PS), 1);
  localparam int unsigned WAIT_MAX = RCD_CYC + CAC_CYC + RP_CYC + 4;

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             row_hit, ras_expired, ref_pend, ref_ack;
  logic             trk_open, trk_close, timer_run;
  logic [ROW_W-1:0] trk_row;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  edo_ref_timer #(
    .PERIOD   (REF_CYC),
    .WAIT_MAX (WAIT_MAX)
  ) u_ref (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (timer_run),
    .ref_ack  (ref_ack),
    .ref_pend (ref_pend)
  );

  edo_row_track #(
    .ROW_W     (ROW_W),
    .AGE_MAX   (RASX_CYC),
    .AGE_SLACK (CAC_CYC + 2)
  ) u_row (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .open_en     (trk_open),
    .open_row    (trk_row),
    .close_en    (trk_close),
    .cmp_row     (req_row),
    .row_hit     (row_hit),
    .age_expired (ras_expired)
  );

  edo_access_fsm #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .BUS_W    (BUS_W),
    .DQ_W     (DQ_W),
    .INIT_CYC (INIT_CYC),
    .RCD_CYC  (RCD_CYC),
    .CAC_CYC  (CAC_CYC),
    .RP_CYC   (RP_CYC),
    .REFL_CYC (REFL_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_we      (req_we),
    .req_row     (req_row),
    .req_col     (req_col),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .row_hit     (row_hit),
    .ras_expired (ras_expired),
    .ref_pend    (ref_pend),
    .ref_ack     (ref_ack),
    .trk_open    (trk_open),
    .trk_row     (trk_row),
    .trk_close   (trk_close),
    .timer_run   (timer_run),
    .dram_addr   (dram_addr),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .oe_n        (dram_oe_n),
    .dq_out      (dram_dq_out),
    .dq_oe       (dram_dq_oe),
    .dq_in       (dram_dq_in)
  );

  // precharge counter used by the assertions below
  logic [7:0] hi_cnt_q, hi_cnt_d;
  always_comb begin
    hi_cnt_d = '0;
    if (dram_ras_n) hi_cnt_d = (hi_cnt_q == '1) ? hi_cnt_q : hi_cnt_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) hi_cnt_q <= '0;
    else             hi_cnt_q <= hi_cnt_d;
  end

  // R6: the row strobe falls only after a full precharge
  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(dram_ras_n) |-> (hi_cnt_q >= 8'(RP_CYC)));

  // R7: a refresh row strobe fall follows a column strobe already low
  p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

  // R1: nothing is accepted and no strobe is active during power-up wait
  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (u_fsm.st_q == S_INIT) |-> (dram_ras_n && dram_cas_n && !req_ready));

endmodule

// File: tb/edo_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb_top;

  localparam int RC_MIN   = 11;   // 84 ns at 8 ns
  localparam int RP_MIN   = 4;    // precharge cycles
  localparam int PAGE_CYC = 5;    // CAC + 1
  localparam int RASX     = 100;  // 800 ns row limit
  localparam int INIT_CY  = 20;   // 160 ns power-up wait

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [11:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [3:0]  dram_dq_out;
  logic [3:0]  dram_dq_in = '0;

  always #4 clk = ~clk;

  edo_page_ctrl #(
    .RAS_MAX_NS    (800),
    .REF_WINDOW_US (13107),
    .INIT_NS       (160)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- inline memory model ----------------
  logic [3:0] mem [int];
  logic [3:0] sb  [int];
  logic [3:0] exp_q [$];
  int cas_t [$];
  int cyc = 0, ras_age = 0, cas_age = 0, ras_hi = 0, last_fall = -1;
  int ras_falls = 0, cbr_cnt = 0;
  logic ras_prev = 1'b1, cas_prev = 1'b1;
  logic [11:0] cur_row = '0;
  logic [9:0]  cur_col = '0;

  function automatic logic [3:0] mget(input int k);
    return mem.exists(k) ? mem[k] : 4'h0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (ras_prev && !dram_ras_n) begin
        if (!dram_cas_n) begin
          cbr_cnt++;
          chk(!cas_prev, "R7 cas before ras", int'(cas_prev), 0);
        end else begin
          ras_falls++;
          cur_row = dram_addr;
        end
        if (last_fall >= 0) chk(cyc - last_fall >= RC_MIN, "R10 ras cycle", cyc - last_fall, RC_MIN);
        last_fall = cyc;
        chk(ras_hi >= RP_MIN, "R6 precharge", ras_hi, RP_MIN);
      end
      if (!ras_prev && dram_ras_n)
        chk(ras_age <= RASX + 8, "R9 ras low time", ras_age, RASX + 8);
      ras_age = dram_ras_n ? 0 : ras_age + 1;
      ras_hi  = dram_ras_n ? ras_hi + 1 : 0;
      if (cas_prev && !dram_cas_n && !dram_ras_n) begin
        cur_col = dram_addr[9:0];
        cas_t.push_back(cyc);
        chk(dram_addr[11:10] == 2'b00, "R2 column upper bits", int'(dram_addr[11:10]), 0);
        if (!dram_we_n) begin
          chk(dram_dq_oe, "R3 write drive", int'(dram_dq_oe), 1);
          mem[int'({cur_row, cur_col})] = dram_dq_out;
        end
      end
      cas_age = dram_cas_n ? 0 : cas_age + 1;
      // per-clock strobe rules
      chk(!(dram_dq_oe && (dram_we_n || dram_cas_n || !dram_oe_n)), "R3 drive window",
          int'(dram_dq_oe), 0);
      chk(!(!dram_oe_n && (!dram_we_n || dram_cas_n)), "R4 oe window", int'(dram_oe_n), 1);
      if (!dram_ras_n && !dram_cas_n && !dram_oe_n) begin
        if (cas_age * 8 >= 25 && ras_age * 8 >= 50)
          dram_dq_in = mget(int'({cur_row, cur_col}));
        else
          dram_dq_in = ~mget(int'({cur_row, cur_col}));
      end
      ras_prev = dram_ras_n;
      cas_prev = dram_cas_n;
    end
  end

  // response scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 1, 0);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R11 read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  task automatic issue(input logic we, input logic [21:0] a, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (we) sb[int'(a)] = d;
    else exp_q.push_back(sb.exists(int'(a)) ? sb[int'(a)] : 4'h0);
  endtask

  task automatic after_refresh();
    int c0;
    c0 = cbr_cnt;
    wait (cbr_cnt != c0);
    repeat (15) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all responses returned", exp_q.size(), 0);
  endtask

  task automatic run_tests();
    int f0, c0, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet during power-up wait
    for (int i = 0; i < INIT_CY - 2; i++) begin
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !req_ready,
          "R1 power-up quiet", int'(req_ready), 0);
    end

    // R5 page burst in one row, then read back (R2, R4, R11)
    after_refresh();
    f0 = ras_falls;
    cas_t.delete();
    for (int i = 0; i < 8; i++) issue(1'b1, {12'h5A3, 10'(i * 37)}, 4'(i + 3));
    for (int i = 0; i < 8; i++) issue(1'b0, {12'h5A3, 10'(i * 37)}, 4'h0);
    drain();
    chk(ras_falls - f0 == 1, "R5 one row open for burst", ras_falls - f0, 1);
    for (int i = 1; i < cas_t.size(); i++)
      chk(cas_t[i] - cas_t[i-1] == PAGE_CYC, "R5 page cycle", cas_t[i] - cas_t[i-1], PAGE_CYC);
    for (int i = 0; i < 8; i++)
      chk(mget(int'({12'h5A3, 10'(i * 37)})) == 4'(i + 3), "R2 address split",
          int'(mget(int'({12'h5A3, 10'(i * 37)}))), i + 3);

    // R6 row miss: two different rows
    after_refresh();
    f0 = ras_falls;
    issue(1'b1, {12'h001, 10'h3FF}, 4'hC);
    issue(1'b1, {12'hFFE, 10'h000}, 4'h6);
    issue(1'b0, {12'h001, 10'h3FF}, 4'h0);
    drain();
    chk(ras_falls - f0 == 3, "R6 row miss reopens", ras_falls - f0, 3);

    // R9 idle open row closes after the limit
    after_refresh();
    f0 = ras_falls;
    issue(1'b0, {12'h222, 10'h011}, 4'h0);
    repeat (RASX + 30) @(negedge clk);
    chk(dram_ras_n, "R9 row closed after limit", int'(dram_ras_n), 1);
    issue(1'b0, {12'h222, 10'h012}, 4'h0);
    drain();
    chk(ras_falls - f0 == 2, "R9 same row reopened", ras_falls - f0, 2);

    // R8 refresh arriving while a row is open
    after_refresh();
    repeat (325) @(negedge clk);
    c0 = cbr_cnt;
    f0 = ras_falls;
    issue(1'b1, {12'h777, 10'h055}, 4'h9);
    repeat (80) @(negedge clk);
    chk(cbr_cnt - c0 == 1, "R8 refresh served with row open", cbr_cnt - c0, 1);
    issue(1'b0, {12'h777, 10'h055}, 4'h0);
    drain();
    chk(ras_falls - f0 == 2, "R8 row closed by refresh", ras_falls - f0, 2);

    // R7 refresh rate over an idle window
    c0 = cbr_cnt;
    repeat (4000) @(negedge clk);
    n0 = cbr_cnt - c0;
    chk(n0 >= 10 && n0 <= 11, "R7 refresh rate", n0, 10);

    // R11 mixed traffic across a few rows
    for (int i = 0; i < 60; i++) begin
      logic [21:0] a;
      a = {10'h0, 2'($urandom_range(0, 3)), 10'($urandom_range(0, 15))};
      a[21:10] = 12'h100 + 12'(a[11:10]);
      issue(1'($urandom_range(0, 1)), a, 4'($urandom_range(0, 15)));
    end
    drain();
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule